// File: doc/BRIEF.md
# Majority-Vote Bit Slicer with NRZI Decoding

This block sits behind a tone discriminator in a frequency-shift-keyed receiver and turns the discriminator's signed output into decoded data bits. Each accepted sample is reduced to one raw bit, which is its sign: 1 when the sample is strictly positive. The raw bit is shifted into an 8-bit sample history.

A separate bit-timing stage supplies a decision strobe. At each decision the block takes a 2-of-3 vote over the three newest raw bits to form the line bit, then NRZI-decodes it against the previous line bit.

Samples arrive on a valid-qualified stream with no back-pressure: every cycle with `in_valid` high consumes one sample, and the block never stalls the source. `in_decide` is honoured only together with `in_valid`. The vote then covers the sample accepted in that same cycle. Each decoded bit is offered for exactly one cycle on `out_valid`/`out_bit`. There is no ready input on that side, so the consumer must take the bit in the cycle it is shown.

Top module: `vote_slicer`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid`, `out_bit`, `sample_bits`, `found_bits` and `demod_bits` are all zero.
- R2: The raw bit of a sample is 1 only if the two's-complement sample is greater than zero. Zero and negative samples give 0.
- R3: Each cycle with `in_valid` high shifts the raw bit into `sample_bits` at bit 0, moving older bits toward bit 7. This becomes visible after that clock edge.
- R4: On a decision (`in_valid` and `in_decide` both high), the line bit is 1 when at least two of `{sample_bits[1:0], raw}` are 1. Patterns 111, 110, 101 and 011 give 1, and all others give 0. Older samples have no influence.
- R5: On a decision, the line bit is shifted into `found_bits` at bit 0 and the older bits move up one place.
- R6: The decoded bit is 1 when the new line bit equals the previous one (`found_bits[0]` before the update), and 0 when it differs. After reset the previous line bit counts as 0.
- R7: On a decision, the decoded bit is shifted into `demod_bits` at bit 0. In the next cycle `out_valid` is high for one cycle and `out_bit` carries that decoded bit.
- R8: `in_decide` without `in_valid` has no effect. No pulse appears, and all three histories stay unchanged.
- R9: A sample without a decision changes only `sample_bits`. `out_valid` stays low and `found_bits` and `demod_bits` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present this cycle |
| in_sample | input | SAMPLE_W | Signed discriminator output |
| in_decide | input | 1 | Bit decision at this sample |
| out_valid | output | 1 | One-cycle strobe for a decoded bit |
| out_bit | output | 1 | NRZI-decoded data bit |
| sample_bits | output | HIST_W | Raw-bit history, newest in bit 0 |
| found_bits | output | HIST_W | Line-bit history, newest in bit 0 |
| demod_bits | output | HIST_W | Decoded-bit history, newest in bit 0 |

## Verification
The bench applies all eight three-sample patterns at a decision. A design that voted on only the newest sample, or that voted on the window before the current sample was shifted in, would miss 101, 110 or 011. Zero-valued and most-negative samples probe the sign boundary; treating zero as positive would flip votes. Sequences of held and changing line bits, including the very first decision after reset, expose an inverted NRZI rule or a wrong initial previous bit. Decision strobes without a sample, and samples without a decision, catch designs that leak a pulse or disturb a history.

// File: rtl/vote_slicer_pkg.sv
package vote_slicer_pkg;
  localparam int unsigned DEF_SAMPLE_W = 8;
  localparam int unsigned DEF_HIST_W   = 8;
  localparam int unsigned DEF_VOTE_N   = 3;

  typedef struct packed {
    logic line_bit;
    logic dec_bit;
  } decision_t;
endpackage

// File: rtl/sign_slicer.sv
module sign_slicer #(
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic                raw
);
  localparam int unsigned MSB = SAMPLE_W - 1;
  // strictly positive: sign clear and magnitude nonzero
  always_comb raw = ~sample[MSB] & (|sample[MSB-1:0]);
endmodule

// File: rtl/sample_history.sv
module sample_history #(
  parameter int unsigned HIST_W = 8,
  parameter int unsigned VOTE_N = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              raw,
  output logic [VOTE_N-1:0] window,
  output logic [HIST_W-1:0] hist
);
  // window seen by the vote includes the sample entering this cycle
  always_comb window = {hist[VOTE_N-2:0], raw};

  always_ff @(posedge clk) begin
    if (!rst_n)        hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], raw};
  end
endmodule

// File: rtl/majority_vote.sv
module majority_vote #(
  parameter int unsigned VOTE_N = 3
) (
  input  logic [VOTE_N-1:0] window,
  output logic              vote
);
  localparam int unsigned CNT_W  = $clog2(VOTE_N + 1);
  localparam int unsigned THRESH = VOTE_N / 2 + 1;

  logic [CNT_W-1:0] ones;
  always_comb begin
    ones = '0;
    for (int i = 0; i < VOTE_N; i++) ones = ones + CNT_W'(window[i]);
    vote = (ones >= CNT_W'(THRESH));
  end
endmodule

// File: rtl/nrzi_stage.sv
module nrzi_stage #(
  parameter int unsigned HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              decide,
  input  logic              vote,
  output logic [HIST_W-1:0] found,
  output logic [HIST_W-1:0] demod,
  output logic              strobe,
  output logic              bit_out
);
  import vote_slicer_pkg::*;

  decision_t nxt;
  always_comb begin
    nxt.line_bit = vote;
    nxt.dec_bit  = ~(vote ^ found[0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      found   <= '0;
      demod   <= '0;
      strobe  <= 1'b0;
      bit_out <= 1'b0;
    end else begin
      strobe <= decide;
      if (decide) begin
        found   <= {found[HIST_W-2:0], nxt.line_bit};
        demod   <= {demod[HIST_W-2:0], nxt.dec_bit};
        bit_out <= nxt.dec_bit;
      end
    end
  end
endmodule

// File: rtl/vote_slicer.sv
module vote_slicer #(
  parameter int unsigned SAMPLE_W = vote_slicer_pkg::DEF_SAMPLE_W,
  parameter int unsigned HIST_W   = vote_slicer_pkg::DEF_HIST_W,
  parameter int unsigned VOTE_N   = vote_slicer_pkg::DEF_VOTE_N
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                in_decide,
  output logic                out_valid,
  output logic                out_bit,
  output logic [HIST_W-1:0]   sample_bits,
  output logic [HIST_W-1:0]   found_bits,
  output logic [HIST_W-1:0]   demod_bits
);
  logic              raw;
  logic              vote;
  logic              decide;
  logic [VOTE_N-1:0] window;

  always_comb decide = in_valid & in_decide;

  sign_slicer #(.SAMPLE_W(SAMPLE_W)) u_slice (
    .sample(in_sample), .raw(raw));

  sample_history #(.HIST_W(HIST_W), .VOTE_N(VOTE_N)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(in_valid), .raw(raw),
    .window(window), .hist(sample_bits));

  majority_vote #(.VOTE_N(VOTE_N)) u_vote (
    .window(window), .vote(vote));

  nrzi_stage #(.HIST_W(HIST_W)) u_nrzi (
    .clk(clk), .rst_n(rst_n), .decide(decide), .vote(vote),
    .found(found_bits), .demod(demod_bits),
    .strobe(out_valid), .bit_out(out_bit));
endmodule

// File: rtl/vote_slicer_checker.sv
module vote_slicer_checker #(
  parameter int unsigned HIST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_decide,
  input logic              out_valid,
  input logic              out_bit,
  input logic [HIST_W-1:0] sample_bits,
  input logic [HIST_W-1:0] found_bits,
  input logic [HIST_W-1:0] demod_bits
);
  AST_PULSE_AFTER_DECISION: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_decide) |=> out_valid); // R7
  AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_decide) |=> !out_valid); // R8
  AST_DEMOD_SHIFTS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_decide) |=> demod_bits[HIST_W-1:1] == $past(demod_bits[HIST_W-2:0])); // R7
  AST_BIT_MATCHES_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_bit == demod_bits[0]); // R7
  AST_FOUND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_decide) |=> $stable(found_bits) && $stable(demod_bits)); // R9
  AST_SAMPLES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(sample_bits)); // R8
  AST_NRZI_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_decide) |=> demod_bits[0] == (found_bits[0] == $past(found_bits[0]))); // R6
endmodule

bind vote_slicer vote_slicer_checker #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_decide(in_decide),
  .out_valid(out_valid), .out_bit(out_bit), .sample_bits(sample_bits),
  .found_bits(found_bits), .demod_bits(demod_bits));

// File: tb/vote_slicer_bench.sv
`timescale 1ns/1ps
module vote_slicer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_sample = '0;
  logic       in_decide = 1'b0;
  logic       out_valid, out_bit;
  logic [7:0] sample_bits, found_bits, demod_bits;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_samp = '0, m_found = '0, m_demod = '0;

  always #10 clk = ~clk;

  vote_slicer u_vote_slicer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_decide(in_decide), .out_valid(out_valid), .out_bit(out_bit),
    .sample_bits(sample_bits), .found_bits(found_bits), .demod_bits(demod_bits));

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus, then compare every output against the model
  task automatic step(input logic signed [7:0] s, input logic v, input logic d, input string req);
    logic raw, vote, dec;
    int ones;
    @(negedge clk);
    in_valid = v; in_sample = s; in_decide = d;
    @(posedge clk); #1;
    dec = 1'b0;
    if (v) begin
      raw = (s > 0);
      m_samp = {m_samp[6:0], raw};
      if (d) begin
        ones = int'(m_samp[0]) + int'(m_samp[1]) + int'(m_samp[2]);
        vote = (ones >= 2);
        dec = (vote == m_found[0]);
        m_found = {m_found[6:0], vote};
        m_demod = {m_demod[6:0], dec};
      end
    end
    chk(out_valid == (v && d), {req, " valid"}, 32'(out_valid), 32'(v && d));
    chk(sample_bits == m_samp, {req, " R3 samples"}, 32'(sample_bits), 32'(m_samp));
    chk(found_bits == m_found, {req, " R5 found"}, 32'(found_bits), 32'(m_found));
    chk(demod_bits == m_demod, {req, " demod"}, 32'(demod_bits), 32'(m_demod));
    if (v && d) chk(out_bit == dec, {req, " bit"}, 32'(out_bit), 32'(dec));
    @(negedge clk);
    in_valid = 1'b0; in_decide = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b1; in_decide = 1'b1; in_sample = 8'sd50;
    @(posedge clk); #1;
    chk({out_valid, out_bit, sample_bits, found_bits, demod_bits} == '0, "R1 in reset",
        32'({out_valid, out_bit, demod_bits}), 0);
    @(negedge clk); rst_n = 1'b1; in_valid = 1'b0; in_decide = 1'b0;
    m_samp = '0; m_found = '0; m_demod = '0;
    @(posedge clk); #1;
    chk({out_valid, out_bit, sample_bits, found_bits, demod_bits} == '0, "R1 after reset",
        32'({out_valid, out_bit, demod_bits}), 0);
  endtask

  task automatic test_sign();
    step(8'sd0, 1, 0, "R2 zero");
    chk(sample_bits[0] == 1'b0, "R2 zero raw", 32'(sample_bits[0]), 0);
    step(8'sd1, 1, 0, "R2 plus one");
    chk(sample_bits[0] == 1'b1, "R2 plus one raw", 32'(sample_bits[0]), 1);
    step(-8'sd128, 1, 0, "R2 most negative");
    chk(sample_bits[0] == 1'b0, "R2 negative raw", 32'(sample_bits[0]), 0);
    step(8'sd127, 1, 0, "R2 max");
    chk(sample_bits[0] == 1'b1, "R2 max raw", 32'(sample_bits[0]), 1);
  endtask

  task automatic test_votes();
    for (int p = 0; p < 8; p++) begin
      step(p[2] ? 8'sd40 : -8'sd40, 1, 0, "R4 pre");
      step(p[1] ? 8'sd40 : -8'sd40, 1, 0, "R4 pre");
      step(p[0] ? 8'sd40 : 8'sd0,   1, 1, "R4 vote");
      chk(found_bits[0] == (p == 3 || p >= 5), "R4 pattern", 32'(found_bits[0]), 32'(p == 3 || p >= 5));
    end
  endtask

  task automatic test_nrzi();
    do_reset();
    step(-8'sd9, 1, 1, "R6 first after reset");
    chk(out_bit == 1'b1, "R6 initial previous zero", 32'(out_bit), 1);
    step(8'sd9, 1, 0, "R6 pre"); step(8'sd9, 1, 0, "R6 pre");
    step(8'sd9, 1, 1, "R6 change");
    chk(out_bit == 1'b0, "R6 change gives 0", 32'(out_bit), 0);
    step(8'sd9, 1, 1, "R6 hold");
    chk(out_bit == 1'b1, "R6 hold gives 1", 32'(out_bit), 1);
    for (int i = 0; i < 10; i++) step((i % 3 == 0) ? -8'sd5 : 8'sd5, 1, (i % 2 == 1), "R7 stream");
  endtask

  task automatic test_ignored();
    step(8'sd70, 0, 1, "R8 decide without sample");
    step(-8'sd70, 0, 1, "R8 decide without sample");
    step(8'sd70, 1, 0, "R9 sample only");
    step(-8'sd70, 1, 0, "R9 sample only");
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    test_sign();
    test_votes();
    test_nrzi();
    test_ignored();
    do_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule